// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Sequencer

This block runs an external 12-bit converter with a built-in sample-and-hold, fed through a 4-to-1 analog multiplexer. On its own, the block steps through the four multiplexer inputs. For each input it sets the select lines and waits a settling interval. It then pulls the single read/convert line low to start a conversion and waits for the converter's busy status to drop. Next it raises the line to read the result, holds the read for a minimum number of cycles and captures the 12-bit code. Last, it presents the code as a 16-bit word tagged with the channel number, qualified by a one-cycle valid pulse.

The four inputs carry a zero reference, a half-scale reference, a temperature signal and the pressure signal. Downstream logic uses the first two readings to correct offset and gain, and the third to compensate the fourth. If a conversion never completes, a timeout in the wait phase raises an error pulse and restarts the cycle on the same channel.

Top module: `adc_mux_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it, read/convert is high, mux select is 00, and valid and timeout error are low.
- R2: The mux select encodes 00 zero reference, 01 half-scale reference, 10 temperature and 11 pressure. After each valid word it advances 00, 01, 10, 11, then back to 00. At all other times it stays unchanged.
- R3: Read/convert falls exactly SETTLE_CYC+1 cycles after the cycle in which valid was high. After reset is released it falls SETTLE_CYC cycles later.
- R4: Read/convert stays low while the busy input (1 = converting, 0 = done) is high. The wait ends on the first clock edge that samples busy low. A busy input that is already low ends the wait at the first edge.
- R5: Valid is high READ_CYC+1 cycles after busy is driven low. Read/convert is high in that cycle. The captured code is the value the data input held during the read phase.
- R6: The output word carries the code in bits [11:0], the channel number in bits [13:12] and zeros in bits [15:14]. Bits [13:12] equal the mux select in the valid cycle.
- R7: Valid lasts exactly one cycle for each conversion and is never high while read/convert is low.
- R8: If busy stays high for TIMEOUT_CYC cycles of the wait phase, timeout error pulses for one cycle and read/convert returns high. The channel stays the same, and a new conversion on that channel starts SETTLE_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_busy | input | 1 | Converter status, 1 while converting |
| adc_data | input | 12 | Parallel conversion result |
| adc_rc | output | 1 | Read/convert: low starts conversion, high reads |
| mux_sel | output | 2 | Analog multiplexer channel select |
| out_valid | output | 1 | One-cycle qualifier for out_word |
| out_word | output | 16 | Tagged sample word |
| timeout_err | output | 1 | One-cycle pulse when a conversion times out |

## Verification
Every result has a fixed latency, measured from a cycle counter in the bench. The conversion start falls SETTLE_CYC+1 cycles after a valid pulse, or SETTLE_CYC cycles after reset or a timeout. The tagged word appears READ_CYC+1 cycles after busy drops, and the timeout pulse comes TIMEOUT_CYC cycles after the start. The bench drives the converter model on falling edges and samples outputs there too. It compares each cycle difference against these exact counts rather than waiting loosely for an event. The data input holds a different value during the conversion, so a capture taken at the wrong moment shows up as a wrong code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADC_W  = 12;
    localparam int CH_W   = 2;
    localparam int WORD_W = 16;
    localparam int PAD_W  = WORD_W - CH_W - ADC_W;

    typedef enum logic [1:0] {
        ST_SELECT = 2'd0,
        ST_WAIT   = 2'd1,
        ST_READ   = 2'd2,
        ST_EMIT   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [PAD_W-1:0] pad;
        logic [CH_W-1:0]  chan;
        logic [ADC_W-1:0] code;
    } sample_word_t;

    function automatic sample_word_t pack_sample(input logic [CH_W-1:0] ch,
                                                 input logic [ADC_W-1:0] c);
        sample_word_t w;
        w.pad  = '0;
        w.chan = ch;
        w.code = c;
        return w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;

    assign hit = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (!hit)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_seq_chan_ring.sv
module adc_seq_chan_ring #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] chan
);
    logic [W-1:0] chan_q;

    always_ff @(posedge clk) begin
        if (rst)
            chan_q <= '0;
        else if (step)
            chan_q <= chan_q + 1'b1;
    end

    assign chan = chan_q;
endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC  = 8,
    parameter int READ_CYC    = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_busy,
    input  logic [ADC_W-1:0]  adc_data,
    output logic              adc_rc,
    output logic [CH_W-1:0]   mux_sel,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              timeout_err
);
    localparam int CNT_MAX = max3(SETTLE_CYC, READ_CYC, TIMEOUT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LIM_SETTLE  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_READ    = CNT_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_TIMEOUT = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] limit;
    logic             phase_hit;
    logic             capture, advance, expire;
    logic [ADC_W-1:0] code_q;
    logic             err_q;
    sample_word_t     word;

    always_comb begin
        unique case (state_q)
            ST_SELECT: limit = LIM_SETTLE;
            ST_WAIT:   limit = LIM_TIMEOUT;
            ST_READ:   limit = LIM_READ;
            default:   limit = '0;
        endcase
    end

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (state_d != state_q),
        .limit (limit),
        .hit   (phase_hit)
    );

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        advance = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            ST_SELECT: if (phase_hit) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!adc_busy) begin
                    state_d = ST_READ;
                end else if (phase_hit) begin
                    state_d = ST_SELECT;
                    expire  = 1'b1;
                end
            end
            ST_READ: begin
                if (phase_hit) begin
                    state_d = ST_EMIT;
                    capture = 1'b1;
                end
            end
            ST_EMIT: begin
                state_d = ST_SELECT;
                advance = 1'b1;
            end
            default: state_d = ST_SELECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SELECT;
            code_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= expire;
            if (capture)
                code_q <= adc_data;
        end
    end

    adc_seq_chan_ring #(.W(CH_W)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .step (advance),
        .chan (mux_sel)
    );

    assign word        = pack_sample(mux_sel, code_q);
    assign adc_rc      = (state_q != ST_WAIT);
    assign out_valid   = (state_q == ST_EMIT);
    assign out_word    = word;
    assign timeout_err = err_q;
endmodule

// File: rtl/adc_seq_checks.sv
module adc_seq_checks
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              adc_busy,
    input logic              adc_rc,
    input logic [CH_W-1:0]   mux_sel,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              timeout_err
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (adc_rc && mux_sel == '0 && !out_valid && !timeout_err));

    p_chan_advance_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> (mux_sel == CH_W'($past(mux_sel) + 1'b1)));

    p_chan_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> $stable(mux_sel));

    p_busy_holds_rc_r4: assert property (@(posedge clk) disable iff (rst)
        (!adc_rc && adc_busy) |=> (!adc_rc || timeout_err));

    p_word_tag_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[WORD_W-1:CH_W+ADC_W] == '0 &&
                       out_word[CH_W+ADC_W-1:ADC_W] == mux_sel));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_no_valid_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
        !adc_rc |-> !out_valid);

    p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);

    p_err_rc_high_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (adc_rc && !out_valid));
endmodule

bind adc_mux_sequencer adc_seq_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .adc_busy    (adc_busy),
    .adc_rc      (adc_rc),
    .mux_sel     (mux_sel),
    .out_valid   (out_valid),
    .out_word    (out_word),
    .timeout_err (timeout_err)
);

// File: tb/tb_adc_mux_sequencer.sv
module tb_adc_mux_sequencer;
    localparam int SETTLE  = 8;
    localparam int READ    = 2;
    localparam int TIMEOUT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_busy = 1'b0;
    logic [11:0] adc_data = '0;
    logic        adc_rc;
    logic [1:0]  mux_sel;
    logic        out_valid;
    logic [15:0] out_word;
    logic        timeout_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_valid = 0;

    // data code, busy length in cycles
    localparam logic [19:0] VEC [8] = '{
        {12'h000, 8'd5},  {12'hFFF, 8'd12}, {12'hA5C, 8'd1},  {12'h7FF, 8'd30},
        {12'h800, 8'd3},  {12'h001, 8'd0},  {12'h3C3, 8'd20}, {12'hFFE, 8'd7}
    };

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_mux_sequencer #(.SETTLE_CYC(SETTLE), .READ_CYC(READ), .TIMEOUT_CYC(TIMEOUT)) dut (
        .clk(clk), .rst(rst), .adc_busy(adc_busy), .adc_data(adc_data),
        .adc_rc(adc_rc), .mux_sel(mux_sel), .out_valid(out_valid),
        .out_word(out_word), .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic conv(input logic [11:0] d, input int len, input logic [1:0] ch, input int exp_start);
        int s, t0;
        bit bad_rc;
        bad_rc = 1'b0;
        for (int g = 0; g < 2000 && adc_rc; g++) @(negedge clk);
        s = cyc;
        chk(adc_rc == 1'b0, "R3 conversion start", adc_rc, 0);
        if (exp_start >= 0) chk(s == exp_start, "R3 settle delay", s, exp_start);
        chk(mux_sel == ch, "R2 channel select", mux_sel, ch);
        if (len > 0) begin
            adc_busy = 1'b1;
            adc_data = ~d;
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                if (adc_rc !== 1'b0 || out_valid) bad_rc = 1'b1;
            end
        end
        chk(!bad_rc, "R4 rc low while busy", bad_rc, 0);
        adc_busy = 1'b0;
        adc_data = d;
        t0 = cyc;
        for (int g = 0; g < 2000 && !out_valid; g++) @(negedge clk);
        chk(cyc - t0 == READ + 1, "R5 read latency", cyc - t0, READ + 1);
        chk(adc_rc == 1'b1, "R5 rc high at output", adc_rc, 1);
        chk(out_word == {2'b00, ch, d}, "R6 word format", out_word, {2'b00, ch, d});
        last_valid = cyc;
        @(negedge clk);
        chk(!out_valid, "R7 single valid pulse", out_valid, 0);
        chk(mux_sel == ch + 2'd1, "R2 channel advance", mux_sel, ch + 2'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(adc_rc && mux_sel == 0 && !out_valid && !timeout_err, "R1 reset state",
            {adc_rc, mux_sel, out_valid, timeout_err}, 4'b1000);
        rst = 1'b0;
        last_valid = cyc;

        // table walk: channels rotate through all four codes twice
        for (int i = 0; i < 8; i++)
            conv(VEC[i][19:8], int'(VEC[i][7:0]), 2'(i % 4),
                 (i == 0) ? last_valid + SETTLE : last_valid + SETTLE + 1);

        // timeout on channel 00
        begin
            int s;
            bit seen;
            seen = 1'b0;
            for (int g = 0; g < 2000 && adc_rc; g++) @(negedge clk);
            s = cyc;
            adc_busy = 1'b1;
            for (int g = 0; g < 200 && !seen; g++) begin
                @(negedge clk);
                if (timeout_err) seen = 1'b1;
            end
            chk(cyc - s == TIMEOUT, "R8 timeout latency", cyc - s, TIMEOUT);
            chk(adc_rc == 1'b1, "R8 rc high on timeout", adc_rc, 1);
            chk(mux_sel == 2'd0, "R8 channel kept", mux_sel, 0);
            adc_busy = 1'b0;
            @(negedge clk);
            chk(!timeout_err, "R8 single error pulse", timeout_err, 0);
            conv(12'h5A5, 4, 2'd0, s + TIMEOUT + SETTLE);
        end

        // reset while waiting on channel 01
        for (int g = 0; g < 2000 && adc_rc; g++) @(negedge clk);
        adc_busy = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(adc_rc && mux_sel == 0 && !out_valid && !timeout_err, "R1 reset mid-wait",
            {adc_rc, mux_sel, out_valid, timeout_err}, 4'b1000);
        adc_busy = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        begin
            int r;
            r = cyc;
            conv(12'hC0D, 6, 2'd0, r + SETTLE);
        end

        // busy already low at first wait edge
        conv(12'h123, 0, 2'd1, last_valid + SETTLE + 1);

        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule